// File: doc/BRIEF.md
# Coin Meter, Lockout and DSP Start Command Decoder

This block sits on a host-written control port. Each cycle in which `cmd_valid` is high, the 8-bit `cmd_code` is decoded as one command. Four commands drive single-clock pulses toward the coin meters. Four commands lock or release the coin lockout solenoids, which are grouped in two fixed pairs. Two commands start or stop the coprocessor DSP.

Meter pulses stay blocked after reset. The unblock happens as a side effect of the command that releases the second lockout pair, so the meters cannot pick up counts while the machine powers up. Every output is registered. A command that is accepted at a rising edge shows on the outputs straight after that edge.

Top module: `coin_dsp_ctl`

## Requirements
- R1: After reset, `ctr_pulse` and `lockout` are all zero, `dsp_irq` and `host_halt` are 0, `dsp_halt` is 1, and metering is disabled.
- R2: While metering is disabled, the meter commands 0x08 to 0x0B produce no pulse on `ctr_pulse`.
- R3: While metering is enabled, code 0x08 pulses `ctr_pulse[0]`, 0x09 pulses bit 2, 0x0A pulses bit 1 and 0x0B pulses bit 3. The pulse appears in the cycle after the accepting edge.
- R4: A single meter command raises exactly one `ctr_pulse` bit, for exactly one clock.
- R5: Code 0x0C sets `lockout[0]` and `lockout[2]`. Code 0x0D clears both of them. Neither touches the other bits.
- R6: Code 0x0E sets `lockout[1]` and `lockout[3]`. Code 0x0F clears both of them and also enables metering.
- R7: Code 0x00 clears `dsp_halt`, sets `dsp_irq`, and raises `host_halt` for one clock.
- R8: Code 0x01 clears `dsp_irq` and sets `dsp_halt`.
- R9: Any other code, and any cycle with `cmd_valid` low, leaves every output unchanged and produces no pulses. This includes codes that match a command only in their low bits, such as 0x1C.
- R10: Once enabled, metering stays enabled until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per high cycle |
| cmd_code | input | 8 | Command code |
| ctr_pulse | output | 4 | One-clock meter pulses, one bit per coin |
| lockout | output | 4 | Coin lockout levels, 1 = locked |
| dsp_irq | output | 1 | DSP interrupt request level |
| dsp_halt | output | 1 | DSP halt level |
| host_halt | output | 1 | One-clock request to halt the host CPU |

## Verification
The bench sends meter commands both before and after the enabling command. A design that enabled metering at reset, or on the wrong lockout command, would let through pulses that should have been blocked. It checks the crossed order of the meter bits: a straight index decode would swap coins 1 and 2. It also checks that each pulse falls after one clock. It sends aliasing codes and strobe-low cycles, which would upset the lockouts or the DSP levels if the decode ignored the upper bits or the strobe. A mid-run reset must put metering back to the blocked state.

// File: rtl/coin_dsp_ctl_pkg.sv
package coin_dsp_ctl_pkg;

  localparam int CMD_W   = 8;
  localparam int N_COIN  = 4;
  localparam int N_PAIR  = N_COIN / 2;

  typedef struct packed {
    logic       meter;
    logic [1:0] meter_sel;
    logic       lock_a;
    logic       unlock_a;
    logic       lock_b;
    logic       unlock_b;
    logic       dsp_go;
    logic       dsp_stop;
  } cmd_dec_t;

  // Full-width compare of the command code
  function automatic cmd_dec_t decode_cmd(input logic v, input logic [CMD_W-1:0] c);
    cmd_dec_t d;
    d = '0;
    if (v) begin
      d.meter     = (c[CMD_W-1:2] == 6'b000010);
      d.meter_sel = c[1:0];
      d.lock_a    = (c == 8'h0C);
      d.unlock_a  = (c == 8'h0D);
      d.lock_b    = (c == 8'h0E);
      d.unlock_b  = (c == 8'h0F);
      d.dsp_go    = (c == 8'h00);
      d.dsp_stop  = (c == 8'h01);
    end
    return d;
  endfunction

  // Meter slot: the two selector bits are crossed
  function automatic logic [1:0] meter_slot(input logic [1:0] sel);
    return {sel[0], sel[1]};
  endfunction

endpackage

// File: rtl/coin_cmd_decode.sv
module coin_cmd_decode
  import coin_dsp_ctl_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output cmd_dec_t         dec
);
  always_comb dec = decode_cmd(cmd_valid, cmd_code);
endmodule

// File: rtl/coin_meter_pulse.sv
module coin_meter_pulse
  import coin_dsp_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [1:0]        sel,
  input  logic              arm,
  output logic [N_COIN-1:0] pulse,
  output logic              count_en
);
  logic [N_COIN-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (fire && count_en) nxt[meter_slot(sel)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse    <= '0;
      count_en <= 1'b0;
    end else begin
      pulse <= nxt;
      if (arm) count_en <= 1'b1;
    end
  end
endmodule

// File: rtl/coin_lockout_regs.sv
module coin_lockout_regs
  import coin_dsp_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PAIR-1:0] set_pair,
  input  logic [N_PAIR-1:0] clr_pair,
  output logic [N_COIN-1:0] lockout
);
  // Pair p drives coins p and p+N_PAIR
  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    logic lvl;
    always_ff @(posedge clk) begin
      if (!rst_n)           lvl <= 1'b0;
      else if (set_pair[p]) lvl <= 1'b1;
      else if (clr_pair[p]) lvl <= 1'b0;
    end
    assign lockout[p]          = lvl;
    assign lockout[p + N_PAIR] = lvl;
  end
endmodule

// File: rtl/coin_dsp_start.sv
module coin_dsp_start (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic stop,
  output logic dsp_irq,
  output logic dsp_halt,
  output logic host_halt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsp_irq   <= 1'b0;
      dsp_halt  <= 1'b1;
      host_halt <= 1'b0;
    end else begin
      host_halt <= go;
      if (go) begin
        dsp_irq  <= 1'b1;
        dsp_halt <= 1'b0;
      end else if (stop) begin
        dsp_irq  <= 1'b0;
        dsp_halt <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/coin_dsp_ctl.sv
module coin_dsp_ctl
  import coin_dsp_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic [3:0]       ctr_pulse,
  output logic [3:0]       lockout,
  output logic             dsp_irq,
  output logic             dsp_halt,
  output logic             host_halt
);
  cmd_dec_t dec;
  logic     count_en;

  coin_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .dec       (dec)
  );

  coin_meter_pulse u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (dec.meter),
    .sel      (dec.meter_sel),
    .arm      (dec.unlock_b),
    .pulse    (ctr_pulse),
    .count_en (count_en)
  );

  coin_lockout_regs u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_pair ({dec.lock_b, dec.lock_a}),
    .clr_pair ({dec.unlock_b, dec.unlock_a}),
    .lockout  (lockout)
  );

  coin_dsp_start u_dsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (dec.dsp_go),
    .stop      (dec.dsp_stop),
    .dsp_irq   (dsp_irq),
    .dsp_halt  (dsp_halt),
    .host_halt (host_halt)
  );
endmodule

// File: rtl/coin_dsp_ctl_chk.sv
module coin_dsp_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_code,
  input logic [3:0] ctr_pulse,
  input logic [3:0] lockout,
  input logic       dsp_irq,
  input logic       dsp_halt,
  input logic       host_halt,
  input logic       count_en
);
  // R2: no pulse unless metering was enabled before the accepting edge
  assert_pulse_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    |ctr_pulse |-> $past(count_en));

  // R3: a pulse follows an accepted meter command
  assert_pulse_from_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    |ctr_pulse |-> $past(cmd_valid && cmd_code[7:2] == 6'b000010));

  // R4: at most one meter bit at a time
  assert_pulse_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctr_pulse));

  // R9: lockouts only move on an accepted command
  assert_lock_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_valid) |-> $stable(lockout));

  // R7: host halt request only after the start command
  assert_host_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_halt |-> $past(cmd_valid && cmd_code == 8'h00));

  // R8: interrupt falls only on the stop command
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsp_irq) |-> $past(cmd_valid && cmd_code == 8'h01));

  // R10: enable never drops outside reset
  assert_enable_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(count_en) && $past(rst_n) |-> count_en);
endmodule

bind coin_dsp_ctl coin_dsp_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .ctr_pulse (ctr_pulse),
  .lockout   (lockout),
  .dsp_irq   (dsp_irq),
  .dsp_halt  (dsp_halt),
  .host_halt (host_halt),
  .count_en  (count_en)
);

// File: tb/tb_coin_dsp_ctl.sv
module tb_coin_dsp_ctl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] req;
    logic       v;
    logic [7:0] code;
    logic [3:0] pulse;
    logic [3:0] lock;
    logic       irq;
    logic       halt;
    logic       hh;
  } vec_t;

  // Walked in order from reset; each row: command, then outputs one edge later
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{8'd2, 1'b1, 8'h08, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0}, // R2 blocked
    '{8'd6, 1'b1, 8'h0E, 4'b0000, 4'b1010, 1'b0, 1'b1, 1'b0}, // R6 lock 1,3
    '{8'd5, 1'b1, 8'h0C, 4'b0000, 4'b1111, 1'b0, 1'b1, 1'b0}, // R5 lock 0,2
    '{8'd5, 1'b1, 8'h0D, 4'b0000, 4'b1010, 1'b0, 1'b1, 1'b0}, // R5 unlock
    '{8'd2, 1'b1, 8'h09, 4'b0000, 4'b1010, 1'b0, 1'b1, 1'b0}, // R2 blocked
    '{8'd6, 1'b1, 8'h0F, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0}, // R6 unlock+enable
    '{8'd3, 1'b1, 8'h08, 4'b0001, 4'b0000, 1'b0, 1'b1, 1'b0}, // R3
    '{8'd3, 1'b1, 8'h09, 4'b0100, 4'b0000, 1'b0, 1'b1, 1'b0}, // R3
    '{8'd3, 1'b1, 8'h0A, 4'b0010, 4'b0000, 1'b0, 1'b1, 1'b0}, // R3
    '{8'd3, 1'b1, 8'h0B, 4'b1000, 4'b0000, 1'b0, 1'b1, 1'b0}, // R3
    '{8'd9, 1'b0, 8'h0C, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0}, // R9 strobe low
    '{8'd9, 1'b1, 8'h05, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0}, // R9 unused
    '{8'd7, 1'b1, 8'h00, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1}, // R7
    '{8'd9, 1'b1, 8'h1C, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0}, // R9 alias
    '{8'd8, 1'b1, 8'h01, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0}  // R8
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [3:0] ctr_pulse, lockout;
  logic       dsp_irq, dsp_halt, host_halt;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coin_dsp_ctl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .ctr_pulse(ctr_pulse), .lockout(lockout), .dsp_irq(dsp_irq),
    .dsp_halt(dsp_halt), .host_halt(host_halt)
  );

  task automatic check_out(input string tag, input logic [3:0] ep, input logic [3:0] el,
                           input logic ei, input logic eh, input logic ehh);
    checks++;
    if (ctr_pulse !== ep || lockout !== el || dsp_irq !== ei ||
        dsp_halt !== eh || host_halt !== ehh) begin
      fails++;
      $display("FAIL %s: got pulse=%b lock=%b irq=%b halt=%b hh=%b exp pulse=%b lock=%b irq=%b halt=%b hh=%b",
               tag, ctr_pulse, lockout, dsp_irq, dsp_halt, host_halt, ep, el, ei, eh, ehh);
    end
  endtask

  // Called at a negedge; drives, then returns at the next negedge
  task automatic send(input logic v, input logic [7:0] c);
    cmd_valid = v;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check_out("R1 reset", 4'b0, 4'b0, 1'b0, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].v, VEC[i].code);
      check_out($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].pulse, VEC[i].lock,
                VEC[i].irq, VEC[i].halt, VEC[i].hh);
    end

    // R4: pulse lasts one clock
    send(1'b1, 8'h0A);
    check_out("R4 pulse high", 4'b0010, 4'b0, 1'b0, 1'b1, 1'b0);
    send(1'b0, 8'h00);
    check_out("R4 pulse low", 4'b0000, 4'b0, 1'b0, 1'b1, 1'b0);

    // R7: host halt lasts one clock
    send(1'b1, 8'h00);
    send(1'b0, 8'h00);
    check_out("R7 host_halt drop", 4'b0, 4'b0, 1'b1, 1'b0, 1'b0);

    // R10: enable survives lockout traffic, cleared by reset
    send(1'b1, 8'h0E);
    send(1'b1, 8'h0B);
    check_out("R10 still enabled", 4'b1000, 4'b1010, 1'b1, 1'b0, 1'b0);
    do_reset();
    check_out("R1 mid reset", 4'b0, 4'b0, 1'b0, 1'b1, 1'b0);
    send(1'b1, 8'h08);
    check_out("R10 blocked after reset", 4'b0, 4'b0, 1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule